// File: doc/BRIEF.md
# Multi-Line SPI Chip-Select Controller

This block drives a set of SPI chip-select pins for a host controller that shares one serial bus among several attached devices. A binary index from the control register names the target device. All other lines are held at the idle level implied by a global polarity bit. The line that is chosen is driven in one of two ways:

- In manual mode, software writes its pin level directly.
- In automatic mode, the transfer engine's burst strobes frame it: a start strobe asserts it and a done strobe releases it.

Every pin comes straight from a flip-flop, so a change to the index or to any mode field shows up at the pins cleanly on the following clock edge. The number of lines is a parameter, and the default is four. The index is 2 bits wide. In the full control word it sits at bits 13:12, the manual-mode flag at bit 16, the manual level at bit 17 and the active-low flag at bit 4. The surrounding register block slices those bits out and presents them here as separate inputs.

Top module: `spi_cs_ctrl`

## Requirements
- R1: While `rst` is high, every pin is driven high at the next edge. After reset no burst is pending, so in automatic mode with no strobe the selected line stays inactive.
- R2: An index value k below the line count selects pin `cs_o[k]`. A new index reaches the pins at the first clock edge after it is applied.
- R3: When `manual_en` is 1, the selected pin takes the raw value of `manual_level` at the next edge. Neither `active_low` nor the burst strobes affect it.
- R4: Every non-selected pin is driven to the value of `active_low` at the next edge: 1 for active-low devices, 0 for active-high devices.
- R5: When `manual_en` is 0, the selected pin becomes active at the edge after a `burst_start` pulse and stays active until a `burst_done` pulse. Active means 0 when `active_low` is 1 and 1 when it is 0. With no burst in progress the pin is inactive.
- R6: A `burst_done` pulse returns the selected pin to its inactive level at the next edge. If `burst_start` and `burst_done` arrive in the same cycle, the start wins and the burst is active afterwards.
- R7: If the index changes during an automatic burst, the active level moves to the newly selected pin at the next edge, and the previous pin returns to idle.
- R8: At most one pin differs from the idle level implied by the `active_low` value of the preceding cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_index | input | IDX_W (2) | Binary number of the target device |
| manual_en | input | 1 | 1 = software level mode, 0 = burst-framed mode |
| manual_level | input | 1 | Raw pin level for the selected line in manual mode |
| active_low | input | 1 | 1 = devices select on low; sets the idle level of the lines |
| burst_start | input | 1 | One-cycle pulse from the transfer engine opening a burst |
| burst_done | input | 1 | One-cycle pulse from the transfer engine closing a burst |
| cs_o | output | NUM_CS (4) | Registered chip-select pins |

## Verification
The bench drives both polarities so that a design which hardwires idle-high, or inverts the manual level through the polarity bit, shows the wrong pin value. It pulses start and done in the same cycle, both from idle and during a burst, which catches a tracker that lets the done pulse win or that drops a burst already in progress. It moves the index in the middle of a burst, so a design that latches the target at burst start leaves the old pin asserted. It also pulses start while in manual mode, which exposes any leak of burst state into the software-driven level.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic {
    CS_MODE_AUTO   = 1'b0,
    CS_MODE_MANUAL = 1'b1
  } cs_mode_e;

endpackage

// File: rtl/cs_index_decode.sv
module cs_index_decode #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 2
) (
  input  logic [IDX_W-1:0]  index_i,
  output logic [NUM_CS-1:0] sel_o
);

  // Out-of-range codes (possible when NUM_CS is not a power of two)
  // select nothing, so every line stays idle.
  always_comb begin
    sel_o = '0;
    for (int k = 0; k < NUM_CS; k++) begin
      if (index_i == IDX_W'(k)) sel_o[k] = 1'b1;
    end
  end

  always_comb begin
    a_sel_onehot_r2: assert ($onehot0(sel_o) || $isunknown(index_i))
      else $error("decoder selected more than one line");
  end

endmodule

// File: rtl/cs_burst_tracker.sv
module cs_burst_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic done_i,
  output logic busy_next_o
);

  logic busy_q;

  // A start pulse overrides a simultaneous done pulse.
  assign busy_next_o = start_i | (busy_q & ~done_i);

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else     busy_q <= busy_next_o;
  end

  p_start_wins_r6: assert property (@(posedge clk) disable iff (rst)
    start_i |=> busy_q)
    else $error("burst not open after start");

  p_done_closes_r6: assert property (@(posedge clk) disable iff (rst)
    (done_i && !start_i) |=> !busy_q)
    else $error("burst still open after done");

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !start_i) |=> !busy_q)
    else $error("burst opened without a start pulse");

endmodule

// File: rtl/cs_line_driver.sv
module cs_line_driver
  import cs_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     selected_i,
  input  cs_mode_e mode_i,
  input  logic     manual_level_i,
  input  logic     active_low_i,
  input  logic     burst_i,
  output logic     pin_o
);

  logic pin_d;

  always_comb begin
    if (!selected_i)                 pin_d = active_low_i;
    else if (mode_i == CS_MODE_MANUAL) pin_d = manual_level_i;
    else if (burst_i)                pin_d = ~active_low_i;
    else                             pin_d = active_low_i;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_o <= RESET_LEVEL;
    else     pin_o <= pin_d;
  end

  p_unsel_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !selected_i |=> pin_o == $past(active_low_i))
    else $error("unselected line not at idle level");

  p_manual_raw_r3: assert property (@(posedge clk) disable iff (rst)
    (selected_i && mode_i == CS_MODE_MANUAL) |=> pin_o == $past(manual_level_i))
    else $error("manual level not driven");

  p_auto_active_r5: assert property (@(posedge clk) disable iff (rst)
    (selected_i && mode_i == CS_MODE_AUTO && burst_i) |=> pin_o != $past(active_low_i))
    else $error("selected line not active during burst");

  p_auto_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (selected_i && mode_i == CS_MODE_AUTO && !burst_i) |=> pin_o == $past(active_low_i))
    else $error("selected line active outside burst");

endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import cs_pkg::*;
#(
  parameter int   NUM_CS      = 4,
  parameter logic RESET_LEVEL = 1'b1,
  localparam int  IDX_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  cs_index,
  input  logic              manual_en,
  input  logic              manual_level,
  input  logic              active_low,
  input  logic              burst_start,
  input  logic              burst_done,
  output logic [NUM_CS-1:0] cs_o
);

  logic [NUM_CS-1:0] sel;
  logic              busy_next;
  cs_mode_e          mode;

  assign mode = manual_en ? CS_MODE_MANUAL : CS_MODE_AUTO;

  cs_index_decode #(
    .NUM_CS (NUM_CS),
    .IDX_W  (IDX_W)
  ) u_decode (
    .index_i (cs_index),
    .sel_o   (sel)
  );

  cs_burst_tracker u_burst (
    .clk         (clk),
    .rst         (rst),
    .start_i     (burst_start),
    .done_i      (burst_done),
    .busy_next_o (busy_next)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_line
    cs_line_driver #(
      .RESET_LEVEL (RESET_LEVEL)
    ) u_line (
      .clk            (clk),
      .rst            (rst),
      .selected_i     (sel[g]),
      .mode_i         (mode),
      .manual_level_i (manual_level),
      .active_low_i   (active_low),
      .burst_i        (busy_next),
      .pin_o          (cs_o[g])
    );
  end

  p_reset_level_r1: assert property (@(posedge clk)
    rst |=> cs_o == {NUM_CS{RESET_LEVEL}})
    else $error("pins not at reset level");

  p_single_active_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(cs_o ^ {NUM_CS{$past(active_low)}}) <= 1)
    else $error("more than one line away from idle");

  p_index_follow_r2: assert property (@(posedge clk) disable iff (rst)
    (manual_en && (int'(cs_index) < NUM_CS))
      |=> cs_o[$past(cs_index)] == $past(manual_level))
    else $error("indexed line did not follow");

endmodule

// File: tb/tb_spi_cs_ctrl.sv
module tb_spi_cs_ctrl;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cs_index;
  logic       manual_en, manual_level, active_low, burst_start, burst_done;
  logic [3:0] cs_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit busy_m = 0;

  always #5 clk = ~clk;

  spi_cs_ctrl dut (
    .clk (clk), .rst (rst), .cs_index (cs_index), .manual_en (manual_en),
    .manual_level (manual_level), .active_low (active_low),
    .burst_start (burst_start), .burst_done (burst_done), .cs_o (cs_o)
  );

  function automatic logic [3:0] model(logic [1:0] idx, logic man, logic lvl,
                                       logic al, bit busy);
    logic [3:0] v;
    v = {4{al}};
    if (man)       v[idx] = lvl;
    else if (busy) v[idx] = ~al;
    return v;
  endfunction

  task automatic check(string req, logic [3:0] exp);
    checks++;
    if (cs_o !== exp) begin
      errors++;
      $display("FAIL %s: cs_o=%b expected=%b", req, cs_o, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
  task automatic step(string req, logic [1:0] idx, logic man, logic lvl, logic al,
                      logic st, logic dn);
    cs_index = idx; manual_en = man; manual_level = lvl; active_low = al;
    burst_start = st; burst_done = dn;
    @(negedge clk);
    busy_m = st | (busy_m & ~dn);
    check(req, model(idx, man, lvl, al, busy_m));
    burst_start = 0; burst_done = 0;
  endtask

  task automatic test_reset();
    rst = 1; cs_index = 2'd1; manual_en = 1; manual_level = 0; active_low = 0;
    burst_start = 1; burst_done = 0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 4'b1111);
    rst = 0; busy_m = 0;
    step("R1 no burst after reset", 2'd0, 0, 0, 1, 0, 0);
    check("R1 idle pins", 4'b1111);
  endtask

  task automatic test_manual();
    for (int i = 0; i < 4; i++) step("R2 manual index", 2'(i), 1, 0, 1, 0, 0);
    step("R3 manual level high", 2'd3, 1, 1, 1, 0, 0);
    check("R3 raw high", 4'b1111);
    step("R3 active-high raw", 2'd2, 1, 1, 0, 0, 0);
    check("R3 literal", 4'b0100);
    step("R3 start ignored in manual", 2'd2, 1, 0, 0, 1, 0);
    check("R3 literal 2", 4'b0000);
    step("R3 close burst", 2'd2, 1, 0, 0, 0, 1);
  endtask

  task automatic test_idle();
    step("R4 idle low", 2'd1, 0, 1, 0, 0, 0);
    check("R4 literal low", 4'b0000);
    step("R4 idle high", 2'd1, 0, 0, 1, 0, 0);
    check("R4 literal high", 4'b1111);
  endtask

  task automatic test_auto();
    step("R5 start active-low", 2'd1, 0, 0, 1, 1, 0);
    check("R5 literal", 4'b1101);
    step("R5 hold", 2'd1, 0, 0, 1, 0, 0);
    step("R6 done", 2'd1, 0, 0, 1, 0, 1);
    check("R6 literal", 4'b1111);
    step("R5 start active-high", 2'd3, 0, 0, 0, 1, 0);
    check("R5 literal high", 4'b1000);
    step("R6 done high", 2'd3, 0, 0, 0, 0, 1);
    check("R6 literal high", 4'b0000);
  endtask

  task automatic test_same_cycle();
    step("R6 start+done from idle", 2'd0, 0, 0, 1, 1, 1);
    check("R6 literal start wins", 4'b1110);
    step("R6 start+done in burst", 2'd0, 0, 0, 1, 1, 1);
    step("R6 close", 2'd0, 0, 0, 1, 0, 1);
  endtask

  task automatic test_move();
    step("R7 open", 2'd0, 0, 0, 1, 1, 0);
    step("R7 move index", 2'd2, 0, 0, 1, 0, 0);
    check("R7 literal", 4'b1011);
    step("R8 move again", 2'd3, 0, 0, 1, 0, 0);
    check("R8 single line", 4'b0111);
    step("R7 close", 2'd3, 0, 0, 1, 0, 1);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_manual();
    test_idle();
    test_auto();
    test_same_cycle();
    test_move();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule